// File: doc/BRIEF.md
# Contactless Frame Assembler

This block turns a packet of bytes into the ordered symbol stream a contactless tag link puts on air. A start pulse captures the configuration: the count of full bytes, a count of extra bits (0 to 7) in one partial byte, and flags that turn on per-byte parity, start and end markers, a 16-bit CRC, and a mode that trims the front of the first byte. Bytes arrive on a valid/ready stream. Each strobe of `bit_en` sends one symbol: a data or parity bit on `out_bit`/`out_bit_vld`, or a marker on `out_sof` or `out_eof`. Modulation, coding, timing and memory fetch are handled elsewhere.

A state machine drives the block. From IDLE, a start goes to SOF when markers are enabled, otherwise to SEL. SOF emits the start marker on a strobe and goes to SEL. SEL is a cycle with no output. It picks the next chunk in fixed priority: the discard-trimmed first byte, then the full bytes, then the partial byte, then the CRC bytes, then the end. For a byte chunk SEL goes to FETCH. For a CRC byte it loads that byte and goes straight to BITS. At the end it goes to EOF, or to DONE when markers are off. FETCH raises `in_ready` and goes to BITS on a handshake. BITS shifts out one bit per strobe. After the last bit it goes to PAR when the chunk carries parity, otherwise back to SEL. PAR emits the parity bit and returns to SEL. EOF emits the end marker and goes to DONE. DONE pulses `done` for one cycle and returns to IDLE.

Top module: `cl_frame_asm`

## Requirements
- R1: Every chunk is sent least significant bit first, so a full byte goes out as b0, b1, up to b7.
- R2: With parity enabled, each full byte (data or CRC) is followed by one odd parity bit, chosen so that the eight data bits plus parity hold an odd number of ones. With parity disabled, no parity bit is sent.
- R3: With markers enabled, a start marker comes before the first bit and an end marker comes after the last bit. With markers disabled, neither marker appears.
- R4: With CRC enabled, two CRC bytes follow all data, low byte first. The CRC uses the reflected polynomial 0x8408 with preset 0x6363 and no final inversion. It is computed over every byte read, all 8 bits of each. With no bytes read it is 0x6363, and for the bytes 0x50, 0x00 it is 0xCD57.
- R5: An extra-bit count N other than 0, with discard mode off, reads one more byte after the full bytes. Only its N low bits b0..b(N-1) are sent, with no parity bit.
- R6: With discard mode on and N other than 0, the first byte read supplies only its top N bits b(8-N)..b7. These are followed by parity over all 8 bits when parity is enabled, and then the full bytes. With N equal to 0, discard mode has no effect.
- R7: Exactly the full-byte count plus one (when N is not 0) bytes are taken from the stream, in order.
- R8: Each `bit_en` strobe produces at most one of `out_sof`, `out_eof`, `out_bit_vld`, and no symbol appears without a strobe.
- R9: A start pulse latches the configuration in IDLE. A start pulse, or a change of the configuration inputs, during a frame has no effect on that frame.
- R10: `done` is a one-cycle pulse in the cycle after the end marker was emitted, or after the last bit when markers are off. `busy` is low in the cycle after `done`.
- R11: After reset the block is idle: `busy`, `done` and `in_ready` are low and no symbol is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame; takes effect only in IDLE |
| cfg_full_bytes | input | CNT_W | Number of full data bytes |
| cfg_extra_bits | input | 3 | Bits in one partial byte (0 = none) |
| cfg_parity_en | input | 1 | Insert odd parity after full bytes |
| cfg_frame_en | input | 1 | Emit start and end markers |
| cfg_crc_en | input | 1 | Append the two CRC bytes |
| cfg_discard_en | input | 1 | Partial byte goes first, trimmed to its top bits |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Block accepts a stream byte |
| bit_en | input | 1 | Symbol strobe |
| out_bit | output | 1 | Data or parity bit value |
| out_bit_vld | output | 1 | `out_bit` is emitted this strobe |
| out_sof | output | 1 | Start marker emitted this strobe |
| out_eof | output | 1 | End marker emitted this strobe |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
On every cycle the assertions check that at most one symbol kind fires per strobe, that a chunk never shifts past its bit count, that `done` is a single pulse following the end marker, and that the latched configuration holds through a start pulse mid-frame. Only the bench scenarios can show the full symbol order: bit order, parity values, the CRC bytes, partial and discard trimming, and the number of bytes consumed. They compare the whole stream against a model built from the requirements, under continuous and gapped strobes and a stalling source.

// File: rtl/cl_frame_pkg.sv
package cl_frame_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_SOF, S_SEL, S_FETCH, S_BITS, S_PAR, S_EOF, S_DONE
    } fsm_t;

    typedef enum logic [2:0] {
        SRC_DISC, SRC_FULL, SRC_PART, SRC_CRC, SRC_END
    } src_t;

    typedef struct packed {
        logic       par_en;
        logic       frame_en;
        logic       crc_en;
        logic       disc_en;
        logic [2:0] extra;
    } cfg_t;

    // odd parity: total ones over data plus parity is odd
    function automatic logic odd_par(input logic [7:0] d);
        return ~(^d);
    endfunction

    // bytewise step of the reflected 0x8408 CRC
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [7:0] ch;
        ch = d ^ c[7:0];
        ch = ch ^ {ch[3:0], 4'b0000};
        return {8'h00, c[15:8]} ^ {ch, 8'h00} ^ {5'b00000, ch, 3'b000} ^ {12'h000, ch[7:4]};
    endfunction

endpackage

// File: rtl/cl_frame_crc.sv
module cl_frame_crc #(
    parameter logic [15:0] PRESET = 16'h6363
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    import cl_frame_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc <= PRESET;
        else if (clr)
            crc <= PRESET;
        else if (upd)
            crc <= crc_step(crc, din);
    end

    // R4
    crc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !upd);

endmodule

// File: rtl/cl_frame_shift.sv
module cl_frame_shift #(
    parameter int W  = 8,
    localparam int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  ld_data,
    input  logic [CW-1:0] ld_cnt,
    input  logic          shift,
    output logic          lsb,
    output logic          last
);
    logic [W-1:0]  sh;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (load) begin
            sh  <= ld_data;
            cnt <= ld_cnt;
        end else if (shift) begin
            sh  <= sh >> 1;
            cnt <= cnt - 1'b1;
        end
    end

    assign lsb  = sh[0];
    assign last = (cnt == CW'(1));

    // R5
    shift_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> (cnt != '0));

endmodule

// File: rtl/cl_frame_asm.sv
module cl_frame_asm #(
    parameter int          CNT_W     = 8,
    parameter logic [15:0] CRC_PRESET = 16'h6363
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cfg_full_bytes,
    input  logic [2:0]       cfg_extra_bits,
    input  logic             cfg_parity_en,
    input  logic             cfg_frame_en,
    input  logic             cfg_crc_en,
    input  logic             cfg_discard_en,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             bit_en,
    output logic             out_bit,
    output logic             out_bit_vld,
    output logic             out_sof,
    output logic             out_eof,
    output logic             busy,
    output logic             done
);
    import cl_frame_pkg::*;

    localparam int BYTE_W = 8;
    localparam int BCW    = $clog2(BYTE_W + 1);

    fsm_t             st, nxt;
    cfg_t             cfg_q;
    src_t             src, kind_q;
    logic [CNT_W-1:0] full_left;
    logic             disc_pend, part_pend;
    logic [1:0]       crc_left;
    logic             par_q, chunk_par;

    logic [15:0]      crc_val;
    logic [7:0]       crc_byte;
    logic             sh_load, sh_shift, sh_lsb, sh_last;
    logic [7:0]       ld_data;
    logic [BCW-1:0]   ld_cnt;
    logic [3:0]       disc_amt;
    logic             fetch_hs;

    // chunk priority
    always_comb begin
        if (disc_pend)              src = SRC_DISC;
        else if (full_left != '0)   src = SRC_FULL;
        else if (part_pend)         src = SRC_PART;
        else if (crc_left != 2'd0)  src = SRC_CRC;
        else                        src = SRC_END;
    end

    assign crc_byte = (crc_left == 2'd2) ? crc_val[7:0] : crc_val[15:8];
    assign fetch_hs = (st == S_FETCH) && in_valid;
    assign disc_amt = 4'd8 - {1'b0, cfg_q.extra};

    assign sh_load  = ((st == S_SEL) && (src == SRC_CRC)) || fetch_hs;
    assign sh_shift = (st == S_BITS) && bit_en;

    always_comb begin
        if (st == S_SEL) begin
            ld_data = crc_byte;
            ld_cnt  = BCW'(BYTE_W);
        end else if (kind_q == SRC_DISC) begin
            ld_data = in_data >> disc_amt;
            ld_cnt  = BCW'(cfg_q.extra);
        end else if (kind_q == SRC_FULL) begin
            ld_data = in_data;
            ld_cnt  = BCW'(BYTE_W);
        end else begin
            ld_data = in_data;
            ld_cnt  = BCW'(cfg_q.extra);
        end
    end

    cl_frame_shift #(.W(BYTE_W)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .ld_data (ld_data),
        .ld_cnt  (ld_cnt),
        .shift   (sh_shift),
        .lsb     (sh_lsb),
        .last    (sh_last)
    );

    cl_frame_crc #(.PRESET(CRC_PRESET)) crc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((st == S_IDLE) && start),
        .upd   (fetch_hs),
        .din   (in_data),
        .crc   (crc_val)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:  if (start) nxt = cfg_frame_en ? S_SOF : S_SEL;
            S_SOF:   if (bit_en) nxt = S_SEL;
            S_SEL: begin
                unique case (src)
                    SRC_CRC: nxt = S_BITS;
                    SRC_END: nxt = cfg_q.frame_en ? S_EOF : S_DONE;
                    default: nxt = S_FETCH;
                endcase
            end
            S_FETCH: if (in_valid) nxt = S_BITS;
            S_BITS:  if (bit_en && sh_last) nxt = chunk_par ? S_PAR : S_SEL;
            S_PAR:   if (bit_en) nxt = S_SEL;
            S_EOF:   if (bit_en) nxt = S_DONE;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            full_left <= '0;
            disc_pend <= 1'b0;
            part_pend <= 1'b0;
            crc_left  <= 2'd0;
            kind_q    <= SRC_END;
            par_q     <= 1'b0;
            chunk_par <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: if (start) begin
                    cfg_q     <= '{par_en: cfg_parity_en, frame_en: cfg_frame_en,
                                   crc_en: cfg_crc_en, disc_en: cfg_discard_en,
                                   extra: cfg_extra_bits};
                    full_left <= cfg_full_bytes;
                    disc_pend <= cfg_discard_en && (cfg_extra_bits != 3'd0);
                    part_pend <= !cfg_discard_en && (cfg_extra_bits != 3'd0);
                    crc_left  <= cfg_crc_en ? 2'd2 : 2'd0;
                end
                S_SEL: begin
                    kind_q <= src;
                    if (src == SRC_CRC) begin
                        par_q     <= odd_par(crc_byte);
                        chunk_par <= cfg_q.par_en;
                        crc_left  <= crc_left - 2'd1;
                    end
                end
                S_FETCH: if (in_valid) begin
                    par_q <= odd_par(in_data);
                    unique case (kind_q)
                        SRC_DISC: begin
                            disc_pend <= 1'b0;
                            chunk_par <= cfg_q.par_en;
                        end
                        SRC_FULL: begin
                            full_left <= full_left - 1'b1;
                            chunk_par <= cfg_q.par_en;
                        end
                        default: begin
                            part_pend <= 1'b0;
                            chunk_par <= 1'b0;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready    = (st == S_FETCH);
        out_sof     = bit_en && (st == S_SOF);
        out_eof     = bit_en && (st == S_EOF);
        out_bit_vld = bit_en && ((st == S_BITS) || (st == S_PAR));
        out_bit     = (st == S_PAR) ? par_q : sh_lsb;
        busy        = (st != S_IDLE);
        done        = (st == S_DONE);
    end

    // R8
    sym_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_sof, out_eof, out_bit_vld}));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R10
    done_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cfg_q.frame_en) |-> $past(out_eof));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(cfg_q));

endmodule

// File: tb/cl_frame_asm_tb.sv
module cl_frame_asm_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] cfg_full_bytes = '0;
    logic [2:0]       cfg_extra_bits = '0;
    logic             cfg_parity_en = 1'b0;
    logic             cfg_frame_en = 1'b0;
    logic             cfg_crc_en = 1'b0;
    logic             cfg_discard_en = 1'b0;
    logic [7:0]       in_data;
    logic             in_valid;
    logic             in_ready;
    logic             bit_en;
    logic             out_bit, out_bit_vld, out_sof, out_eof, busy, done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [7:0] src [64];
    int  src_n   = 0;
    int  src_idx = 0;
    bit  slow_en  = 0;
    bit  stall_en = 0;

    int  exp_sym [512];
    int  exp_n;
    int  rec_sym [512];
    int  rec_n;
    bit  rec_on = 0;
    int  eof_cyc, done_cyc, r8_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    cl_frame_asm #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_full_bytes(cfg_full_bytes), .cfg_extra_bits(cfg_extra_bits),
        .cfg_parity_en(cfg_parity_en), .cfg_frame_en(cfg_frame_en),
        .cfg_crc_en(cfg_crc_en), .cfg_discard_en(cfg_discard_en),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .bit_en(bit_en), .out_bit(out_bit), .out_bit_vld(out_bit_vld),
        .out_sof(out_sof), .out_eof(out_eof), .busy(busy), .done(done)
    );

    // stream source and strobe pattern
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (in_valid && in_ready) src_idx <= src_idx + 1;
    end
    assign in_data  = (src_idx < 64) ? src[src_idx] : 8'h00;
    assign in_valid = (src_idx < src_n) && (!stall_en || cyc[1]);
    assign bit_en   = !slow_en || cyc[0];

    // symbol monitor: 0/1 bit, 2 start marker, 3 end marker
    always @(negedge clk) begin
        if (rec_on) begin
            if ((int'(out_sof) + int'(out_eof) + int'(out_bit_vld)) > 1) r8_bad++;
            if (!bit_en && (out_sof || out_eof || out_bit_vld)) r8_bad++;
            if (out_sof) begin rec_sym[rec_n] = 2; rec_n++; end
            if (out_bit_vld) begin rec_sym[rec_n] = int'(out_bit); rec_n++; end
            if (out_eof) begin rec_sym[rec_n] = 3; rec_n++; eof_cyc = cyc; end
            if (done) done_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic logic [15:0] crc_model(input int first, input int n);
        logic [15:0] c = 16'h6363;
        for (int i = first; i < first + n; i++) begin
            c = c ^ {8'h00, src[i]};
            for (int k = 0; k < 8; k++)
                c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        return c;
    endfunction

    task automatic push_bits(input logic [7:0] b, input int lo, input int hi, input bit par);
        for (int k = lo; k <= hi; k++) begin exp_sym[exp_n] = int'(b[k]); exp_n++; end
        if (par) begin
            exp_sym[exp_n] = ((b[0]+b[1]+b[2]+b[3]+b[4]+b[5]+b[6]+b[7]) % 2 == 0) ? 1 : 0;
            exp_n++;
        end
    endtask

    task automatic build_exp(input int nf, input int nx, input bit par, input bit fr,
                             input bit crc, input bit disc);
        int base = 0;
        logic [15:0] c;
        exp_n = 0;
        if (fr) begin exp_sym[exp_n] = 2; exp_n++; end
        if (disc && nx != 0) begin
            push_bits(src[0], 8 - nx, 7, par);
            base = 1;
        end
        for (int i = 0; i < nf; i++) push_bits(src[base + i], 0, 7, par);
        if (!disc && nx != 0) push_bits(src[nf], 0, nx - 1, 1'b0);
        if (crc) begin
            c = crc_model(0, nf + ((nx != 0) ? 1 : 0));
            push_bits(c[7:0], 0, 7, par);
            push_bits(c[15:8], 0, 7, par);
        end
        if (fr) begin exp_sym[exp_n] = 3; exp_n++; end
    endtask

    task automatic run_frame(input string req, input int seed, input int nf, input int nx,
                             input bit par, input bit fr, input bit crc, input bit disc,
                             input bit slow, input bit stall, input bit disturb);
        int nbytes = nf + ((nx != 0) ? 1 : 0);
        int mism = -1;
        int wait_n = 0;
        for (int i = 0; i < 64; i++) src[i] = 8'((seed * 37 + i * 91 + 5) & 255);
        @(negedge clk);
        src_n = 0; src_idx = 0; slow_en = slow; stall_en = stall;
        build_exp(nf, nx, par, fr, crc, disc);
        rec_n = 0; eof_cyc = -1; done_cyc = -1; r8_bad = 0; rec_on = 1;
        src_n = nbytes;
        cfg_full_bytes = CNT_W'(nf); cfg_extra_bits = 3'(nx);
        cfg_parity_en = par; cfg_frame_en = fr; cfg_crc_en = crc; cfg_discard_en = disc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (10) @(negedge clk);
            start = 1'b1;
            cfg_full_bytes = CNT_W'(nf + 3); cfg_parity_en = !par;
            cfg_frame_en = !fr; cfg_crc_en = !crc; cfg_extra_bits = 3'(nx + 1);
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && wait_n < 5000) begin @(negedge clk); wait_n++; end
        @(negedge clk);
        rec_on = 0;
        chk(!busy, {req, " busy low after done (R10)"}, int'(busy), 0);
        for (int i = 0; i < exp_n && i < rec_n; i++)
            if (mism < 0 && rec_sym[i] != exp_sym[i]) mism = i;
        if (mism >= 0)
            chk(1'b0, {req, " symbol mismatch, index ", $sformatf("%0d", mism)},
                rec_sym[mism], exp_sym[mism]);
        else
            chk(rec_n == exp_n, {req, " symbol count"}, rec_n, exp_n);
        chk(src_idx == nbytes, {req, " bytes consumed (R7)"}, src_idx, nbytes);
        if (fr) chk(done_cyc == eof_cyc + 1, {req, " done follows end marker (R10)"},
                    done_cyc, eof_cyc + 1);
        chk(r8_bad == 0, {req, " one symbol per strobe (R8)"}, r8_bad, 0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(!busy, "R11 busy after reset", int'(busy), 0);
        chk(!done, "R11 done after reset", int'(done), 0);
        chk(!in_ready, "R11 in_ready after reset", int'(in_ready), 0);
        chk(!(out_sof || out_eof || out_bit_vld), "R11 no symbol after reset",
            int'(out_sof || out_eof || out_bit_vld), 0);
    endtask

    task automatic test_crc_const();
        src[0] = 8'h50; src[1] = 8'h00;
        chk(crc_model(0, 2) == 16'hCD57, "R4 model check value", int'(crc_model(0, 2)), 'hCD57);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_crc_const();
        run_frame("R1 R2 R3 parity+markers", 1, 3, 0, 1, 1, 0, 0, 0, 0, 0);
        run_frame("R2 R3 bare bytes",        2, 2, 0, 0, 0, 0, 0, 0, 0, 0);
        run_frame("R4 crc with parity",      3, 2, 0, 1, 1, 1, 0, 0, 0, 0);
        run_frame("R4 crc of empty frame",   4, 0, 0, 1, 1, 1, 0, 0, 0, 0);
        run_frame("R5 trailing 3 bits",      5, 2, 3, 1, 1, 0, 0, 0, 0, 0);
        run_frame("R5 trailing bits + crc",  6, 1, 5, 1, 0, 1, 0, 0, 0, 0);
        run_frame("R6 discard 4 bits",       7, 2, 4, 1, 1, 0, 1, 0, 0, 0);
        run_frame("R6 discard 7 no parity",  8, 1, 7, 0, 1, 1, 1, 0, 0, 0);
        run_frame("R6 discard with N=0",     9, 2, 0, 1, 1, 0, 1, 0, 0, 0);
        run_frame("R8 gapped strobe+stall", 10, 4, 2, 1, 1, 1, 0, 1, 1, 0);
        run_frame("R3 empty markers only",  11, 0, 0, 1, 1, 0, 0, 0, 0, 0);
        run_frame("R9 restart ignored",     12, 5, 3, 1, 1, 0, 0, 0, 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule